// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control state machine of a multi-channel memory-to-memory DMA engine. It serves one channel at a time. When master enable is set and at least one channel request is pending, it takes the lowest-numbered requesting channel. It then reads three words from that channel's descriptor slot: first the control word, then the source end pointer, then the destination end pointer. It copies the number of words given by the control word from source to destination. It then waits for the channel to withdraw its request and writes the control word back with its count cleared. It holds a one-cycle done state, during which it pulses that channel's done line, and returns to idle.

All descriptor and data traffic uses one simple memory master port. A request holds its address and write data steady until the memory returns ready in the same cycle. If ready does not arrive within a programmable number of cycles, the machine parks in a stalled state until software clears it. A read-only status word reports the live state code, the number of channels minus one and the registered master-enable flag. The status word reads as zero while reset is held.

The states, with their 4-bit codes, are: IDLE (0), RD_CTRL (1), RD_SRCP (2), RD_DSTP (3), RD_DATA (4), WR_DATA (5), WAIT_CLR (6), WR_CTRL (7), STALL (8) and DONE (9). The transitions are:
- IDLE goes to RD_CTRL when enabled and a request is pending.
- RD_CTRL goes to RD_SRCP, and RD_SRCP goes to RD_DSTP.
- RD_DSTP goes to RD_DATA when the count is non-zero and to WAIT_CLR when it is zero.
- RD_DATA goes to WR_DATA.
- WR_DATA goes back to RD_DATA while words remain and to WAIT_CLR after the last word.
- WAIT_CLR goes to WR_CTRL once the request drops.
- WR_CTRL goes to DONE, and DONE goes to IDLE.
- Any access state goes to STALL on a timeout, and STALL goes to IDLE on a clear.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset is released the status word reads 0x001F0000 (with 32 channels). Its fields are: bits 20:16 hold the channel count minus one, bits 7:4 hold the state code (IDLE = 0), and bit 0 holds the master-enable flag sampled one clock after `master_en`. All other bits read zero.
- R2: While `rst_n` is low the status word reads 0x00000000.
- R3: While the master-enable flag is 0, the machine stays in IDLE, issues no memory access and ignores every channel request.
- R4: When several requests are pending in IDLE, the channel with the lowest index is served first.
- R5: Channel c's descriptor slot starts at `desc_base + 16*c`. The source end pointer is at offset 0, the destination end pointer at offset 4 and the control word at offset 8. They are read in the order control word (code 1), source end pointer (code 2), destination end pointer (code 3).
- R6: The word count N is held in control bits 9:0. Word i (i = 0 to N-1) is read from `src_end - 4*(N-1-i)` in state 4 and written to `dst_end - 4*(N-1-i)` in state 5. The two states alternate once per word, so no other address is written. When N = 0 the machine goes straight from code 3 to code 6.
- R7: The machine stays in WAIT_CLR (code 6) for as long as the served channel's request stays high.
- R8: In WR_CTRL (code 7) the control word is written back to offset 8 of the channel's slot with bits 9:0 cleared and all other bits unchanged.
- R9: DONE (code 9) lasts exactly one cycle. During that cycle only `chan_done[c]` is high, and the next state is IDLE.
- R10: An access stalls when `mem_ready` has not come in its first `tmo_limit` cycles (a limit of 0 acts as 1). The machine then enters STALL (code 8) and stays there with no memory access and no done pulse until `stall_clr` is seen, after which it returns to IDLE.
- R11: The state code never takes a value from 0xA to 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Master enable, registered into the status flag |
| chan_req | input | NCH | Per-channel transfer request levels |
| desc_base | input | AW | Byte address of the descriptor table |
| tmo_limit | input | TW | Cycles allowed for memory ready per access |
| stall_clr | input | 1 | Software clear that leaves STALL |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory access complete this cycle |
| chan_done | output | NCH | One-cycle per-channel completion pulse |
| status | output | 32 | Read-only status word |

## Verification
The copy path is tried with word counts of 0, 1 and several words, on low, middle and top channel numbers. Each run uses its own memory latency and its own length of request hold. The counts separate an off-by-one in the end-pointer arithmetic from a missing or extra word: the word just past the block is checked to be unchanged. The zero count shows whether the data phase is really skipped. Latencies just below the timeout limit and exactly at it separate the stall threshold from a late-by-one counter, and a zero limit shows the lower-bound clamp. The logged sequence of state codes tells a wrong fetch order apart from one that reaches the same memory result.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'h0,
        ST_RD_CTRL  = 4'h1,
        ST_RD_SRCP  = 4'h2,
        ST_RD_DSTP  = 4'h3,
        ST_RD_DATA  = 4'h4,
        ST_WR_DATA  = 4'h5,
        ST_WAIT_CLR = 4'h6,
        ST_WR_CTRL  = 4'h7,
        ST_STALL    = 4'h8,
        ST_DONE     = 4'h9
    } seq_state_t;

    // width of the word count inside the control word
    localparam int CNT_W = 10;
    // log2 of the bytes per descriptor slot
    localparam int SLOT_LG = 4;
    localparam logic [3:0] OFS_SRCP = 4'h0;
    localparam logic [3:0] OFS_DSTP = 4'h4;
    localparam logic [3:0] OFS_CTRL = 4'h8;

    function automatic logic is_access(seq_state_t s);
        return (s == ST_RD_CTRL) || (s == ST_RD_SRCP) || (s == ST_RD_DSTP) ||
               (s == ST_RD_DATA) || (s == ST_WR_DATA) || (s == ST_WR_CTRL);
    endfunction

endpackage

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
    parameter int NCH = 32,
    parameter int CW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CW-1:0]  idx
);
    logic [NCH-1:0] below;
    logic [NCH-1:0] grant;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_pfx
            if (g == 0) begin : g_first
                assign below[g] = 1'b0;
            end else begin : g_rest
                assign below[g] = below[g-1] | req[g-1];
            end
        end
    endgenerate

    assign grant = req & ~below;
    assign any   = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grant[i]) idx = CW'(i);
        end
    end

    // R4
    arb_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx] && ((req & ((NCH'(1) << idx) - NCH'(1))) == '0)));

    // R4
    arb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

// File: rtl/dma_seq_tmo.sv
module dma_seq_tmo #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          ready,
    input  logic [TW-1:0] limit,
    output logic          hit
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || ready) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign hit = active && !ready &&
                 (({1'b0, cnt_q} + (TW+1)'(1)) >= {1'b0, limit});

    // R10
    tmo_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ready && !hit) |=> (cnt_q == $past(cnt_q) + TW'(1)));

endmodule

// File: rtl/dma_seq_stat.sv
module dma_seq_stat #(
    parameter int NCH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  state_code,
    input  logic        en_flag,
    output logic [31:0] status
);
    always_comb begin
        status = '0;
        if (rst_n) begin
            status[20:16] = 5'(NCH - 1);
            status[7:4]   = state_code;
            status[0]     = en_flag;
        end
    end

    // R11
    stat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:4] <= 4'h9);

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
#(
    parameter int NCH = 32,
    parameter int CW  = 5,
    parameter int AW  = 32,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           master_en,
    input  logic [NCH-1:0] chan_req,
    input  logic           stall_clr,
    input  logic [AW-1:0]  desc_base,
    input  logic           arb_any,
    input  logic [CW-1:0]  arb_idx,
    input  logic           tmo_hit,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ready,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic [NCH-1:0] chan_done,
    output logic [3:0]     state_code,
    output logic           en_flag
);
    seq_state_t st_q, st_d;

    logic                en_q;
    logic [CW-1:0]       ch_q;
    logic [DW-CNT_W-1:0] ctrl_hi_q;
    logic [CNT_W-1:0]    rem_q;
    logic [AW-1:0]       src_q;
    logic [AW-1:0]       dst_q;
    logic [DW-1:0]       data_q;

    logic [AW-1:0]       slot_addr;
    logic [AW-1:0]       word_ofs;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (en_q && arb_any) st_d = ST_RD_CTRL;
            ST_RD_CTRL:  if (mem_ready) st_d = ST_RD_SRCP;
                         else if (tmo_hit) st_d = ST_STALL;
            ST_RD_SRCP:  if (mem_ready) st_d = ST_RD_DSTP;
                         else if (tmo_hit) st_d = ST_STALL;
            ST_RD_DSTP:  if (mem_ready) st_d = (rem_q != '0) ? ST_RD_DATA : ST_WAIT_CLR;
                         else if (tmo_hit) st_d = ST_STALL;
            ST_RD_DATA:  if (mem_ready) st_d = ST_WR_DATA;
                         else if (tmo_hit) st_d = ST_STALL;
            ST_WR_DATA:  if (mem_ready) st_d = (rem_q == CNT_W'(1)) ? ST_WAIT_CLR : ST_RD_DATA;
                         else if (tmo_hit) st_d = ST_STALL;
            ST_WAIT_CLR: if (!chan_req[ch_q]) st_d = ST_WR_CTRL;
            ST_WR_CTRL:  if (mem_ready) st_d = ST_DONE;
                         else if (tmo_hit) st_d = ST_STALL;
            ST_STALL:    if (stall_clr) st_d = ST_IDLE;
            ST_DONE:     st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // channel, descriptor and data holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            ch_q      <= '0;
            ctrl_hi_q <= '0;
            rem_q     <= '0;
            src_q     <= '0;
            dst_q     <= '0;
            data_q    <= '0;
        end else begin
            en_q <= master_en;
            if (st_q == ST_IDLE && en_q && arb_any) ch_q <= arb_idx;
            if (mem_ready) begin
                unique case (st_q)
                    ST_RD_CTRL: begin
                        ctrl_hi_q <= mem_rdata[DW-1:CNT_W];
                        rem_q     <= mem_rdata[CNT_W-1:0];
                    end
                    ST_RD_SRCP: src_q  <= AW'(mem_rdata);
                    ST_RD_DSTP: dst_q  <= AW'(mem_rdata);
                    ST_RD_DATA: data_q <= mem_rdata;
                    ST_WR_DATA: rem_q  <= rem_q - CNT_W'(1);
                    default: ;
                endcase
            end
        end
    end

    assign slot_addr = desc_base + (AW'(ch_q) << SLOT_LG);
    assign word_ofs  = AW'(rem_q - CNT_W'(1)) << 2;

    // outputs
    always_comb begin
        mem_req   = is_access(st_q);
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        chan_done = '0;
        unique case (st_q)
            ST_RD_CTRL: mem_addr = slot_addr + AW'(OFS_CTRL);
            ST_RD_SRCP: mem_addr = slot_addr + AW'(OFS_SRCP);
            ST_RD_DSTP: mem_addr = slot_addr + AW'(OFS_DSTP);
            ST_RD_DATA: mem_addr = src_q - word_ofs;
            ST_WR_DATA: begin
                mem_we    = 1'b1;
                mem_addr  = dst_q - word_ofs;
                mem_wdata = data_q;
            end
            ST_WR_CTRL: begin
                mem_we    = 1'b1;
                mem_addr  = slot_addr + AW'(OFS_CTRL);
                mem_wdata = {ctrl_hi_q, CNT_W'(0)};
            end
            ST_DONE:    chan_done = NCH'(1) << ch_q;
            default: ;
        endcase
    end

    assign state_code = st_q;
    assign en_flag    = en_q;

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !en_q) |=> (st_q == ST_IDLE));

    // R6
    data_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RD_DATA && mem_ready) |=> (st_q == ST_WR_DATA));

    // R7
    wait_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_CLR && chan_req[ch_q]) |=> (st_q == ST_WAIT_CLR));

    // R9
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) |=> (st_q == ST_IDLE));

    // R9
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_done));

    // R10
    stall_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && tmo_hit) |=> (st_q == ST_STALL));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STALL && !stall_clr) |=> (st_q == ST_STALL && !mem_req));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
    parameter int NCH = 32,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int TW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           master_en,
    input  logic [NCH-1:0] chan_req,
    input  logic [AW-1:0]  desc_base,
    input  logic [TW-1:0]  tmo_limit,
    input  logic           stall_clr,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ready,
    output logic [NCH-1:0] chan_done,
    output logic [31:0]    status
);
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

    logic          arb_any;
    logic [CW-1:0] arb_idx;
    logic          tmo_hit;
    logic [3:0]    state_code;
    logic          en_flag;

    dma_seq_arb #(.NCH(NCH), .CW(CW)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (chan_req),
        .any   (arb_any),
        .idx   (arb_idx)
    );

    dma_seq_tmo #(.TW(TW)) tmo_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (mem_req),
        .ready  (mem_ready),
        .limit  (tmo_limit),
        .hit    (tmo_hit)
    );

    dma_seq_ctrl #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_en  (master_en),
        .chan_req   (chan_req),
        .stall_clr  (stall_clr),
        .desc_base  (desc_base),
        .arb_any    (arb_any),
        .arb_idx    (arb_idx),
        .tmo_hit    (tmo_hit),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .chan_done  (chan_done),
        .state_code (state_code),
        .en_flag    (en_flag)
    );

    dma_seq_stat #(.NCH(NCH)) stat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_code (state_code),
        .en_flag    (en_flag),
        .status     (status)
    );

endmodule

// File: tb/dma_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0;
    logic [31:0] chan_req = '0;
    logic [31:0] desc_base = '0;
    logic [15:0] tmo_limit = 16'd8;
    logic        stall_clr = 1'b0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] chan_done, status;

    always #2.5 clk = ~clk;

    dma_xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .chan_req(chan_req),
        .desc_base(desc_base), .tmo_limit(tmo_limit), .stall_clr(stall_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .chan_done(chan_done), .status(status)
    );

    // memory model with a selectable ready latency
    logic [31:0] mem [0:1023];
    int lat_sel = 0;
    int lat_cnt = 0;
    assign mem_ready = mem_req && (lat_cnt == lat_sel);
    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) begin
        if (!mem_req || mem_ready) lat_cnt <= 0;
        else lat_cnt <= lat_cnt + 1;
        if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] <= mem_wdata;
    end

    // monitor, sampling at the falling edge
    int checks = 0, errors = 0;
    int done_cycles = 0, req_cycles = 0, bad_code = 0;
    logic [31:0] done_last = '0;
    logic [3:0]  slog [0:63];
    int          log_n = 0;
    logic [3:0]  last_st = 4'h0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (status[7:4] > 4'h9) bad_code++;
            if (status[7:4] != last_st) begin
                if (log_n < 64) slog[log_n] = status[7:4];
                log_n++;
                last_st = status[7:4];
            end
            if (chan_done != '0) begin
                done_cycles++;
                done_last = chan_done;
            end
            if (mem_req) req_cycles++;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_state(logic [3:0] code, int lim, output logic ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            if (status[7:4] == code) begin ok = 1'b1; break; end
            tick();
        end
    endtask

    task automatic wait_done(int base, output logic ok);
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            tick();
            if (done_cycles != base) begin ok = 1'b1; break; end
        end
    endtask

    function automatic logic [31:0] src_end(int ch, int cnt);
        return 32'h400 + ch*32 + 4*((cnt > 0) ? cnt-1 : 0);
    endfunction
    function automatic logic [31:0] dst_end(int ch, int cnt);
        return 32'h800 + ch*32 + 4*((cnt > 0) ? cnt-1 : 0);
    endfunction
    function automatic logic [31:0] ctrl_val(int ch, int cnt);
        return 32'h5A00_0C00 | (ch << 16) | cnt;
    endfunction
    function automatic logic [31:0] pat(int ch, int i);
        return 32'hC0DE_0000 + ch*256 + i;
    endfunction

    task automatic setup_desc(int ch, int cnt);
        for (int i = 0; i < 8; i++) begin
            mem[(32'h400 + ch*32)/4 + i] = pat(ch, i);
            mem[(32'h800 + ch*32)/4 + i] = 32'hDEAD_0000 + i;
        end
        mem[ch*4 + 0] = src_end(ch, cnt);
        mem[ch*4 + 1] = dst_end(ch, cnt);
        mem[ch*4 + 2] = ctrl_val(ch, cnt);
    endtask

    task automatic run_xfer(int ch, int cnt, int lat, int hold);
        logic ok;
        int base;
        logic [3:0] exp [0:63];
        int en_n;
        setup_desc(ch, cnt);
        lat_sel = lat;
        log_n = 0; last_st = 4'h0;
        base = done_cycles;
        chan_req[ch] = 1'b1;
        wait_state(4'h6, 3000, ok);
        chk("R7 wait state reached", 32'(ok), 32'd1);
        for (int h = 0; h < hold; h++) begin
            tick();
            chk("R7 held in wait while request high", 32'(status[7:4]), 32'h6);
        end
        chan_req[ch] = 1'b0;
        wait_done(base, ok);
        chk("R9 done pulse seen", 32'(ok), 32'd1);
        chk("R9 idle after done", 32'(status[7:4]), 32'h0);
        tick();
        chk("R9 single done cycle", 32'(done_cycles - base), 32'd1);
        chk("R9 done channel bit", done_last, 32'd1 << ch);
        for (int i = 0; i < cnt; i++)
            chk("R6 destination word", mem[(32'h800 + ch*32)/4 + i], pat(ch, i));
        chk("R6 word past block untouched", mem[(32'h800 + ch*32)/4 + cnt], 32'hDEAD_0000 + cnt);
        chk("R8 control write-back", mem[ch*4 + 2], ctrl_val(ch, cnt) & ~32'h3FF);
        en_n = 0;
        exp[en_n++] = 4'h1; exp[en_n++] = 4'h2; exp[en_n++] = 4'h3;
        for (int i = 0; i < cnt; i++) begin exp[en_n++] = 4'h4; exp[en_n++] = 4'h5; end
        exp[en_n++] = 4'h6; exp[en_n++] = 4'h7; exp[en_n++] = 4'h9; exp[en_n++] = 4'h0;
        chk("R5 state sequence length", 32'(log_n), 32'(en_n));
        for (int i = 0; i < en_n && i < log_n; i++)
            chk("R5 R6 state sequence entry", 32'(slog[i]), 32'(exp[i]));
    endtask

    // {channel, count, latency, hold}
    localparam logic [31:0] VEC [0:5] = '{
        {8'd3,  8'd2, 8'd0, 8'd0},
        {8'd0,  8'd1, 8'd1, 8'd2},
        {8'd31, 8'd4, 8'd2, 8'd1},
        {8'd7,  8'd0, 8'd0, 8'd3},
        {8'd12, 8'd3, 8'd7, 8'd0},
        {8'd20, 8'd5, 8'd1, 8'd5}
    };

    initial begin
        logic ok;
        int base, rq;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) tick();
        chk("R2 status zero in reset", status, 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1 status after reset", status, 32'h001F_0000);

        // R3: requests ignored while disabled
        rq = req_cycles;
        chan_req[2] = 1'b1;
        repeat (30) tick();
        chk("R3 idle while disabled", 32'(status[7:4]), 32'h0);
        chk("R3 no memory access while disabled", 32'(req_cycles - rq), 32'd0);
        chan_req[2] = 1'b0;
        master_en = 1'b1;
        tick();
        chk("R1 enable flag in status", status, 32'h001F_0001);

        foreach (VEC[v]) begin
            run_xfer(int'(VEC[v][31:24]), int'(VEC[v][23:16]),
                     int'(VEC[v][15:8]), int'(VEC[v][7:0]));
        end

        // R4: lowest channel first
        setup_desc(5, 1); setup_desc(9, 1);
        lat_sel = 0;
        base = done_cycles;
        chan_req[5] = 1'b1; chan_req[9] = 1'b1;
        wait_state(4'h6, 200, ok);
        chan_req[5] = 1'b0;
        wait_done(base, ok);
        chk("R4 lower channel served first", done_last, 32'd1 << 5);
        base = done_cycles;
        wait_state(4'h6, 200, ok);
        chan_req[9] = 1'b0;
        wait_done(base, ok);
        chk("R4 higher channel served next", done_last, 32'd1 << 9);
        tick();

        // R10: limit just above latency completes
        tmo_limit = 16'd3;
        run_xfer(6, 2, 2, 0);
        // R10: zero limit behaves as one
        tmo_limit = 16'd0;
        run_xfer(8, 1, 0, 0);

        // R10: latency equal to limit stalls
        tmo_limit = 16'd3;
        setup_desc(4, 1);
        lat_sel = 3;
        base = done_cycles;
        chan_req[4] = 1'b1;
        wait_state(4'h8, 100, ok);
        chk("R10 stall entered", 32'(ok), 32'd1);
        chan_req[4] = 1'b0;
        rq = req_cycles;
        repeat (10) tick();
        chk("R10 stall held", 32'(status[7:4]), 32'h8);
        chk("R10 no access while stalled", 32'(req_cycles - rq), 32'd0);
        chk("R10 no done from stall", 32'(done_cycles - base), 32'd0);
        chk("R8 control untouched after stall", mem[4*4 + 2], ctrl_val(4, 1));
        stall_clr = 1'b1;
        tick();
        stall_clr = 1'b0;
        chk("R10 idle after clear", 32'(status[7:4]), 32'h0);

        // R2: reset in the middle of a transfer
        tmo_limit = 16'd8;
        lat_sel = 0;
        setup_desc(1, 1);
        chan_req[1] = 1'b1;
        wait_state(4'h6, 200, ok);
        rst_n = 1'b0;
        tick();
        chk("R2 status zero in reset after activity", status, 32'h0);
        chan_req[1] = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 idle after second reset", 32'(status[7:4]), 32'h0);

        chk("R11 no undefined state codes", 32'(bad_code), 32'd0);
        summary();
        $finish;
    end

endmodule